// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block is the hardware half of a receive descriptor ring. Frame bytes arrive one per cycle on a byte stream with start and end markers. The block places them into fixed-size buffers named by a circular table of two-word descriptors kept in an internal descriptor store. It hands each filled buffer to software by setting that descriptor's ownership flag. The first buffer of a frame is tagged, and the whole frame length goes into the last one. A descriptor that software has not yet returned halts reception of the current frame and raises a sticky buffer-not-available flag.

Software sets up the ring and returns buffers through a word write port, and reads descriptors back through a combinational read port. Descriptor word 0 is the address word: buffer base in bits 31:2, wrap flag in bit 1, ownership flag in bit 0. Word 1 is the status word: bit 14 is the start-of-frame tag and bits 11:0 hold the frame length. The walker has four states. IDLE waits for a start byte. FILL holds a descriptor that is partly written. OPEN means a frame continues into a descriptor that has not been checked yet. DROP discards bytes up to the end marker. The transitions are:
- IDLE or DROP to FILL on an accepted start byte.
- FILL to FILL on a middle byte.
- FILL or OPEN to OPEN when a buffer fills.
- FILL or OPEN to IDLE on the last byte.
- IDLE, OPEN or DROP to DROP when the descriptor needed is still owned.
- DROP to IDLE on an end byte.

Top module: `rxring_writer`

## Requirements
- R1: After reset all outputs are low, every descriptor word reads zero and the walker points at descriptor 0.
- R2: An accepted byte is written one cycle later on the buffer port, at the descriptor's address word with bits 1:0 cleared plus the byte's offset inside that buffer.
- R3: A byte without the start marker that arrives while the walker is in IDLE is ignored: nothing is written to a buffer and no descriptor changes.
- R4: The ownership flag (address word bit 0) is set when a descriptor is handed over, either because its buffer is full or because the frame ends in it.
- R5: After a descriptor whose wrap flag (address word bit 1) is set, or after the last descriptor of the ring, the walker continues at descriptor 0. Otherwise it continues at the next index.
- R6: The status word of the first descriptor of a frame has bit 14 set. Later descriptors of the same frame have it clear.
- R7: The status word of the last descriptor of a frame holds the frame length in bits 11:0. Earlier descriptors of the frame hold length 0.
- R8: A buffer is closed after exactly BUF_BYTES bytes, and the frame continues at offset 0 of the next descriptor. A frame that ends on the last byte of a buffer closes in that buffer.
- R9: If the descriptor needed for a byte still has its ownership flag set, that byte and the rest of the frame are dropped and the bna output is set. The walker stays on that descriptor, and the next start byte begins a new frame.
- R10: bna stays set until a cycle with bna_clr high. A new drop in the same cycle as a clear leaves it set.
- R11: rx_done pulses high for one cycle, one cycle after the last byte of a stored frame is accepted.
- R12: Software writes select the word with sw_sel (0 address, 1 status). Clearing the ownership flag makes the descriptor usable for the next byte that needs it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte present this cycle |
| in_data | input | 8 | Frame byte |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| sw_we | input | 1 | Software descriptor write |
| sw_idx | input | IDX_W | Descriptor index for the write |
| sw_sel | input | 1 | Word select: 0 address word, 1 status word |
| sw_wdata | input | 32 | Word written by software |
| sw_rd_idx | input | IDX_W | Descriptor index for the read |
| sw_rd_sel | input | 1 | Word select for the read |
| sw_rd_data | output | 32 | Descriptor word read |
| bna_clr | input | 1 | Clears the buffer-not-available flag |
| buf_we | output | 1 | Buffer byte write strobe |
| buf_addr | output | 32 | Byte address of the buffer write |
| buf_data | output | 8 | Byte written to the buffer |
| rx_done | output | 1 | One-cycle frame-stored pulse |
| bna | output | 1 | Sticky buffer-not-available flag |

## Verification
The bench builds the block with BUF_BYTES = 8 and DEPTH = 4. With these values a 20-byte frame spans three buffers and passes the ring end, and a frame of exactly 8 bytes closes on the last offset of a buffer. A ring of four descriptors runs out within a few frames, so drops at the first byte and in the middle of a frame both occur without long traffic. The same setting lets a wrap flag placed early on descriptor 1 send the walker back to descriptor 0 well before the ring end.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_OPEN = 2'd2,
        ST_DROP = 2'd3
    } rxr_state_e;

    localparam int OWN_BIT  = 0;
    localparam int WRAP_BIT = 1;
    localparam int SOF_BIT  = 14;
    localparam int LEN_W    = 12;
endpackage

// File: rtl/rxr_desc_store.sv
module rxr_desc_store #(
    parameter int DEPTH = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_we,
    input  logic [IDX_W-1:0] sw_idx,
    input  logic             sw_sel,
    input  logic [31:0]      sw_wdata,
    input  logic             hw_we,
    input  logic [31:0]      hw_stat,
    input  logic [IDX_W-1:0] walk_idx,
    output logic [31:0]      walk_addr,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic             rd_sel,
    output logic [31:0]      rd_data
);
    import rxr_pkg::*;

    logic [31:0] addr_mem [DEPTH];
    logic [31:0] stat_mem [DEPTH];

    // Hardware hand-over first; a software write to the same word in the
    // same cycle is scheduled later and takes effect.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                addr_mem[i] <= '0;
                stat_mem[i] <= '0;
            end
        end else begin
            if (hw_we) begin
                addr_mem[walk_idx] <= addr_mem[walk_idx] | 32'd1;
                stat_mem[walk_idx] <= hw_stat;
            end
            if (sw_we) begin
                if (sw_sel) stat_mem[sw_idx] <= sw_wdata;
                else        addr_mem[sw_idx] <= sw_wdata;
            end
        end
    end

    assign walk_addr = addr_mem[walk_idx];
    assign rd_data   = rd_sel ? stat_mem[rd_idx] : addr_mem[rd_idx];

    assert_handover_sets_own_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_we && !(sw_we && !sw_sel && sw_idx == walk_idx))
        |=> addr_mem[$past(walk_idx)][OWN_BIT]);
endmodule

// File: rtl/rxr_walker.sv
module rxr_walker #(
    parameter int BUF_BYTES = 128,
    parameter int DEPTH     = 8,
    parameter int IDX_W     = 3,
    parameter int POS_W     = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic             in_sof,
    input  logic             in_eof,
    input  logic             bna_clr,
    input  logic [31:0]      walk_addr,
    output logic [IDX_W-1:0] walk_idx,
    output logic             hw_we,
    output logic [31:0]      hw_stat,
    output logic             buf_we,
    output logic [31:0]      buf_addr,
    output logic [7:0]       buf_data,
    output logic             rx_done,
    output logic             bna
);
    import rxr_pkg::*;

    localparam logic [POS_W-1:0] LAST_POS = POS_W'(BUF_BYTES - 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

    rxr_state_e       state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d, adv_idx;
    logic [POS_W-1:0] pos_q, pos_d;
    logic [LEN_W-1:0] len_q, len_d, len_base, new_len;
    logic             first_q, first_d, first_eff;
    logic             need_check, take, bna_set, done_set;
    logic             own_cur, wrap_cur;

    assign own_cur  = walk_addr[OWN_BIT];
    assign wrap_cur = walk_addr[WRAP_BIT];
    assign adv_idx  = (wrap_cur || idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
    assign walk_idx = idx_q;
    assign new_len  = len_base + LEN_W'(1);

    always_comb begin
        state_d    = state_q;
        idx_d      = idx_q;
        pos_d      = pos_q;
        len_d      = len_q;
        first_d    = first_q;
        first_eff  = first_q;
        len_base   = len_q;
        need_check = 1'b0;
        take       = 1'b0;
        bna_set    = 1'b0;
        done_set   = 1'b0;
        hw_we      = 1'b0;
        hw_stat    = '0;
        unique case (state_q)
            ST_IDLE, ST_DROP: begin
                if (in_valid) begin
                    if (in_sof) begin
                        need_check = 1'b1;
                        first_eff  = 1'b1;
                        len_base   = '0;
                    end else if (in_eof) begin
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_OPEN: need_check = in_valid;
            ST_FILL: take       = in_valid;
            default: ;
        endcase
        if (need_check) begin
            if (own_cur) begin
                bna_set = 1'b1;
                state_d = in_eof ? ST_IDLE : ST_DROP;
            end else begin
                take = 1'b1;
            end
        end
        if (take) begin
            if (in_eof) begin
                hw_we                = 1'b1;
                hw_stat[LEN_W-1:0]   = new_len;
                hw_stat[SOF_BIT]     = first_eff;
                done_set             = 1'b1;
                idx_d                = adv_idx;
                pos_d                = '0;
                len_d                = '0;
                first_d              = 1'b0;
                state_d              = ST_IDLE;
            end else if (pos_q == LAST_POS) begin
                hw_we                = 1'b1;
                hw_stat[SOF_BIT]     = first_eff;
                idx_d                = adv_idx;
                pos_d                = '0;
                len_d                = new_len;
                first_d              = 1'b0;
                state_d              = ST_OPEN;
            end else begin
                pos_d                = pos_q + 1'b1;
                len_d                = new_len;
                first_d              = first_eff;
                state_d              = ST_FILL;
            end
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            pos_q   <= '0;
            len_q   <= '0;
            first_q <= 1'b0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            pos_q   <= pos_d;
            len_q   <= len_d;
            first_q <= first_d;
        end
    end

    // Output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_we   <= 1'b0;
            buf_addr <= '0;
            buf_data <= '0;
            rx_done  <= 1'b0;
            bna      <= 1'b0;
        end else begin
            buf_we  <= take;
            rx_done <= done_set;
            if (take) begin
                buf_addr <= {walk_addr[31:2], 2'b00} + 32'(pos_q);
                buf_data <= in_data;
            end
            if (bna_set)      bna <= 1'b1;
            else if (bna_clr) bna <= 1'b0;
        end
    end

    assert_write_follows_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> $past(in_valid));
    assert_done_follows_end_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |-> $past(in_valid && in_eof));
    assert_wrap_to_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_we && wrap_cur) |=> (idx_q == '0));
    assert_bna_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bna && !bna_clr) |=> bna);
    assert_open_at_offset_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OPEN) |-> (pos_q == '0));
endmodule

// File: rtl/rxring_writer.sv
module rxring_writer #(
    parameter int BUF_BYTES = 128,
    parameter int DEPTH     = 8,
    localparam int IDX_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic             in_sof,
    input  logic             in_eof,
    input  logic             sw_we,
    input  logic [IDX_W-1:0] sw_idx,
    input  logic             sw_sel,
    input  logic [31:0]      sw_wdata,
    input  logic [IDX_W-1:0] sw_rd_idx,
    input  logic             sw_rd_sel,
    output logic [31:0]      sw_rd_data,
    input  logic             bna_clr,
    output logic             buf_we,
    output logic [31:0]      buf_addr,
    output logic [7:0]       buf_data,
    output logic             rx_done,
    output logic             bna
);
    localparam int POS_W = (BUF_BYTES > 1) ? $clog2(BUF_BYTES) : 1;

    logic [IDX_W-1:0] walk_idx;
    logic [31:0]      walk_addr;
    logic             hw_we;
    logic [31:0]      hw_stat;

    rxr_desc_store #(.DEPTH(DEPTH), .IDX_W(IDX_W)) store_i (
        .clk(clk), .rst_n(rst_n),
        .sw_we(sw_we), .sw_idx(sw_idx), .sw_sel(sw_sel), .sw_wdata(sw_wdata),
        .hw_we(hw_we), .hw_stat(hw_stat),
        .walk_idx(walk_idx), .walk_addr(walk_addr),
        .rd_idx(sw_rd_idx), .rd_sel(sw_rd_sel), .rd_data(sw_rd_data)
    );

    rxr_walker #(.BUF_BYTES(BUF_BYTES), .DEPTH(DEPTH), .IDX_W(IDX_W), .POS_W(POS_W)) walker_i (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
        .bna_clr(bna_clr), .walk_addr(walk_addr), .walk_idx(walk_idx),
        .hw_we(hw_we), .hw_stat(hw_stat),
        .buf_we(buf_we), .buf_addr(buf_addr), .buf_data(buf_data),
        .rx_done(rx_done), .bna(bna)
    );
endmodule

// File: tb/rxring_writer_tb_top.sv
module rxring_writer_tb_top;
    localparam int BB = 8;
    localparam int DP = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
    logic [7:0]  in_data = '0;
    logic        sw_we = 1'b0, sw_sel = 1'b0, sw_rd_sel = 1'b0, bna_clr = 1'b0;
    logic [1:0]  sw_idx = '0, sw_rd_idx = '0;
    logic [31:0] sw_wdata = '0;
    logic [31:0] sw_rd_data, buf_addr;
    logic [7:0]  buf_data;
    logic        buf_we, rx_done, bna;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    rxring_writer #(.BUF_BYTES(BB), .DEPTH(DP)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
        .sw_we(sw_we), .sw_idx(sw_idx), .sw_sel(sw_sel), .sw_wdata(sw_wdata),
        .sw_rd_idx(sw_rd_idx), .sw_rd_sel(sw_rd_sel), .sw_rd_data(sw_rd_data),
        .bna_clr(bna_clr), .buf_we(buf_we), .buf_addr(buf_addr), .buf_data(buf_data),
        .rx_done(rx_done), .bna(bna)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Behavioural reference: mode 0 idle, 1 filling, 2 continuing, 3 dropping
    logic [31:0] m_addr [DP];
    logic [31:0] m_stat [DP];
    int          m_mode, m_idx, m_pos, m_len, m_nxt;
    bit          m_first, m_start, m_take, m_check, m_setb;
    logic        e_we, e_done, e_bna;
    logic [31:0] e_addr;
    logic [7:0]  e_data;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DP; i++) begin m_addr[i] = '0; m_stat[i] = '0; end
            m_mode = 0; m_idx = 0; m_pos = 0; m_len = 0; m_first = 0;
            e_we = 0; e_done = 0; e_bna = 0; e_addr = '0; e_data = '0;
        end else begin
            e_we = 0; e_done = 0; m_setb = 0; m_take = 0; m_check = 0;
            if (in_valid) begin
                m_start = (m_mode == 0 || m_mode == 3) && in_sof;
                if (m_start) begin m_len = 0; m_first = 1; m_pos = 0; m_check = 1; end
                else if (m_mode == 2) m_check = 1;
                else if (m_mode == 1) m_take = 1;
                else if (m_mode == 3 && in_eof) m_mode = 0;
                if (m_check) begin
                    if (m_addr[m_idx][0]) begin m_setb = 1; m_mode = in_eof ? 0 : 3; end
                    else m_take = 1;
                end
                if (m_take) begin
                    e_we = 1; e_data = in_data;
                    e_addr = (m_addr[m_idx] & 32'hFFFF_FFFC) + m_pos;
                    m_len = m_len + 1;
                    m_nxt = (m_addr[m_idx][1] || m_idx == DP - 1) ? 0 : m_idx + 1;
                    if (in_eof) begin
                        m_addr[m_idx] = m_addr[m_idx] | 1;
                        m_stat[m_idx] = (m_first ? 32'h4000 : 32'h0) | (m_len & 32'hFFF);
                        e_done = 1; m_idx = m_nxt; m_pos = 0; m_mode = 0;
                    end else if (m_pos == BB - 1) begin
                        m_addr[m_idx] = m_addr[m_idx] | 1;
                        m_stat[m_idx] = m_first ? 32'h4000 : 32'h0;
                        m_idx = m_nxt; m_pos = 0; m_first = 0; m_mode = 2;
                    end else begin
                        m_pos = m_pos + 1; m_mode = 1;
                    end
                end
            end
            if (sw_we) begin
                if (sw_sel) m_stat[sw_idx] = sw_wdata;
                else        m_addr[sw_idx] = sw_wdata;
            end
            if (m_setb) e_bna = 1;
            else if (bna_clr) e_bna = 0;
        end
        #2;
        if (rst_n) begin
            chk("R2 buf_we", 32'(buf_we), 32'(e_we));
            if (e_we) begin
                chk("R2 buf_addr", buf_addr, e_addr);
                chk("R2 buf_data", 32'(buf_data), 32'(e_data));
            end
            chk("R11 rx_done", 32'(rx_done), 32'(e_done));
            chk("R9 R10 bna", 32'(bna), 32'(e_bna));
        end
    end

    task automatic put(input logic [7:0] d, input bit s, input bit e);
        @(negedge clk);
        in_valid = 1; in_data = d; in_sof = s; in_eof = e;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 0; in_sof = 0; in_eof = 0; sw_we = 0; bna_clr = 0;
        end
    endtask

    task automatic frame(input int n, input int seed);
        for (int i = 0; i < n; i++) put(8'(seed + i), i == 0, i == n - 1);
    endtask

    task automatic sw_write(input int idx, input bit sel, input logic [31:0] d);
        @(negedge clk);
        in_valid = 0; sw_we = 1; sw_idx = 2'(idx); sw_sel = sel; sw_wdata = d;
        @(negedge clk);
        sw_we = 0;
    endtask

    task automatic rd(input int idx, input bit sel, output logic [31:0] v);
        sw_rd_idx = 2'(idx); sw_rd_sel = sel;
        #1 v = sw_rd_data;
    endtask

    task automatic desc_vs_model(input string tag, input int idx);
        logic [31:0] v;
        rd(idx, 0, v); chk(tag, v, m_addr[idx]);
        rd(idx, 1, v); chk(tag, v, m_stat[idx]);
    endtask

    task automatic desc_lit(input string tag, input int idx, input logic [31:0] a, input logic [31:0] s);
        logic [31:0] v;
        rd(idx, 0, v); chk(tag, v, a);
        rd(idx, 1, v); chk(tag, v, s);
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 buf_we", 32'(buf_we), 0);
        chk("R1 rx_done", 32'(rx_done), 0);
        chk("R1 bna", 32'(bna), 0);
        rst_n = 1;
        for (int i = 0; i < DP; i++) desc_lit("R1 descriptor zero", i, 0, 0);
        for (int i = 0; i < DP; i++)
            sw_write(i, 0, 32'h1000 + 32'(i) * 32'h100 + ((i == DP - 1) ? 32'h2 : 32'h0));
        // R3: bytes without a start marker while idle
        put(8'h55, 0, 0); put(8'h56, 0, 0); put(8'h57, 0, 1); idle(2);
        desc_lit("R3 stray bytes ignored", 0, 32'h1000, 0);
        // Short frame into descriptor 0
        frame(3, 8'h10); idle(2);
        desc_lit("R4 R6 R7 short frame", 0, 32'h1001, 32'h4003);
        // 20-byte frame over descriptors 1..3, ring end reached
        frame(20, 8'h30); idle(2);
        desc_lit("R6 R8 first of three", 1, 32'h1101, 32'h4000);
        desc_lit("R7 middle buffer", 2, 32'h1201, 0);
        desc_lit("R5 R7 last with length", 3, 32'h1303, 32'h14);
        // Walker back at descriptor 0, still owned: drop on first byte
        frame(5, 8'h60); idle(2);
        chk("R9 bna set", 32'(bna), 1);
        desc_lit("R9 owned descriptor untouched", 0, 32'h1001, 32'h4003);
        @(negedge clk); bna_clr = 1; idle(1); idle(1);
        chk("R10 bna cleared", 32'(bna), 0);
        // Return descriptors 0 and 1, give 1 an early wrap flag
        sw_write(0, 0, 32'h1000);
        sw_write(1, 0, 32'h1102);
        frame(8, 8'h80); idle(2);
        desc_lit("R8 R12 exact fill", 0, 32'h1001, 32'h4008);
        sw_write(0, 0, 32'h1000);
        frame(12, 8'hA0); idle(2);
        desc_lit("R5 wrap flag first part", 1, 32'h1103, 32'h4000);
        desc_lit("R5 wrap flag back to zero", 0, 32'h1001, 32'h000C);
        desc_lit("R5 descriptor 2 skipped", 2, 32'h1201, 0);
        // Mid-frame drop: descriptor 1 free, descriptor 0 owned
        sw_write(1, 0, 32'h1102);
        frame(10, 8'hC0); idle(2);
        chk("R9 mid-frame bna", 32'(bna), 1);
        desc_lit("R9 partial frame buffer", 1, 32'h1103, 32'h4000);
        // Clear while free: set-priority exercised by model every cycle
        @(negedge clk); bna_clr = 1; idle(1);
        // Walker stayed at 0; return it and send a one-byte frame, then back-to-back
        for (int i = 0; i < DP; i++)
            sw_write(i, 0, 32'h1000 + 32'(i) * 32'h100 + ((i == DP - 1) ? 32'h2 : 32'h0));
        frame(1, 8'hE0);
        frame(2, 8'hE8);
        frame(2, 8'hF0); idle(2);
        desc_lit("R6 R7 one-byte frame", 0, 32'h1001, 32'h4001);
        desc_lit("R11 back-to-back frame", 2, 32'h1201, 32'h4002);
        // Mid-frame start marker is not a new frame
        sw_write(0, 0, 32'h1000);
        put(8'h01, 1, 0); put(8'h02, 1, 0); put(8'h03, 0, 1); idle(2);
        desc_lit("R6 inner start ignored", 3, 32'h1303, 32'h4003);
        for (int i = 0; i < DP; i++) desc_vs_model("R4 final ring state", i);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule